// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block is a serial-peripheral master. It sends one word from a parallel register and receives one word back at the same time. The serial clock comes from a programmable divider. The clock is held low between words, and an active-low slave select marks each word. Software sets the divide value and the word length, places the transmit word on the input, and pulses `start`. When the last bit has been captured, the received word appears with a one-cycle `rxDone` pulse.

`clk` is the double-rate reference, so one divider tick equals two `clk` cycles. With a divide setting `D`, one serial clock period lasts `1 + D` ticks, which is `2*(D+1)` `clk` cycles. Because of the double rate, the low phase of the clock stays exactly half the period when `D` is zero or odd. When `D` is even and nonzero, the low phase lasts `D/2` ticks and the high phase takes the remainder.

Each bit begins with a low phase and then a high phase. The master changes `mosi` on the rising edge and samples `miso` on the falling edge. The bits go out most significant first.

Top module: `spi_clkstop_master`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `mosiOe` is 0 and `rxDone` is 0. While `csN` is high, `sclk` stays 0 and `mosiOe` stays 0.
- R2: During a transfer, every serial clock period lasts `2*(D+1)` `clk` cycles, where `D` is the divide setting captured at start.
- R3: The low phase lasts `D+1` `clk` cycles when `D` is zero or odd. It lasts `D` cycles when `D` is even and nonzero. The high phase lasts the rest of the period.
- R4: `csN` falls on the clock edge that accepts `start`, while `sclk` is low. The first rising `sclk` edge follows one full low phase later.
- R5: `mosi` changes only together with a rising `sclk` edge. It presents the transmit word from bit L-1 down to bit 0, where L is the effective length. `mosiOe` rises with the first rising edge.
- R6: `miso` is sampled on each falling `sclk` edge. `rxWord` holds the L captured bits right-aligned, with the first bit in bit L-1 and all bits above L-1 at zero.
- R7: The edge that produces the last falling `sclk` edge also does three things: it raises `csN`, clears `mosiOe`, and asserts `rxDone` for exactly one cycle with `rxWord` valid.
- R8: The word length request is clamped to the range 8 to 32. A request below 8 gives 8 bits, and a request above 32 gives 32 bits.
- R9: A `start` pulse during a transfer is ignored. It does not change the word being sent, and no new frame opens after the current one ends.
- R10: The divide setting and the word length are captured at start. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSet | input | DIV_W | Divide setting D |
| wordLen | input | LEN_W | Requested word length in bits |
| start | input | 1 | Start request, sampled while idle |
| txWord | input | MAX_BITS | Word to send, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| mosiOe | output | 1 | Output enable for `mosi` (0 means high impedance) |
| rxWord | output | MAX_BITS | Captured word, right-aligned |
| rxDone | output | 1 | One-cycle pulse when `rxWord` is valid |

## Verification
The hardest case to reach from the ports is a second `start`, together with new divider and length values, that arrives in the middle of a frame. The stimulus raises these at the third rising serial edge of selected transfers. The bench then checks that the phase lengths, the bit count and the data all still follow the values captured at the first start, and that `csN` stays high after the frame closes. The even divide settings, which have an unequal duty cycle, and the length clamp are reached through directed cases. A seeded random sweep covers divide settings 0 to 9 and lengths 0 to 40.

// File: rtl/spi_clkstop_pkg.sv
package spi_clkstop_pkg;
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
  } ctlStrobes_t;

  localparam int MIN_BITS = 8;
endpackage

// File: rtl/spi_clkstop_ctrl.sv
module spi_clkstop_ctrl
  import spi_clkstop_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DIV_W-1:0]  divSet,
  input  logic [LEN_W-1:0]  wordLen,
  output ctlStrobes_t       strobes,
  output logic [LEN_W-1:0]  lenNext,
  output logic              sclk,
  output logic              frame
);
  localparam int PH_W = DIV_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divR;
  logic [LEN_W-1:0]  lenR;
  logic [LEN_W-1:0]  bitCnt;
  logic [PH_W-1:0]   phCnt;
  logic [PH_W-1:0]   lowLen, highLen, lowLenIn, period;

  // Clamp the requested length into the supported range.
  always_comb begin
    if (wordLen < LEN_W'(MIN_BITS))      lenNext = LEN_W'(MIN_BITS);
    else if (wordLen > LEN_W'(MAX_BITS)) lenNext = LEN_W'(MAX_BITS);
    else                                 lenNext = wordLen;
  end

  // Phase lengths in clk cycles; one divider tick equals two clk cycles.
  always_comb begin
    lowLen   = (divR == '0 || divR[0]) ? PH_W'(divR) + PH_W'(1) : PH_W'(divR);
    period   = (PH_W'(divR) + PH_W'(1)) << 1;
    highLen  = period - lowLen;
    lowLenIn = (divSet == '0 || divSet[0]) ? PH_W'(divSet) + PH_W'(1) : PH_W'(divSet);
  end

  always_comb begin
    strobes.load   = (state == S_IDLE) && start;
    strobes.rise   = (state == S_LOW)  && (phCnt == '0);
    strobes.fall   = (state == S_HIGH) && (phCnt == '0);
    strobes.finish = strobes.fall && (bitCnt == LEN_W'(lenR - LEN_W'(1)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divR   <= '0;
      lenR   <= LEN_W'(MIN_BITS);
      bitCnt <= '0;
      phCnt  <= '0;
      sclk   <= 1'b0;
      frame  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (strobes.load) begin
            divR   <= divSet;
            lenR   <= lenNext;
            bitCnt <= '0;
            phCnt  <= lowLenIn - PH_W'(1);
            frame  <= 1'b1;
            state  <= S_LOW;
          end
        end
        S_LOW: begin
          if (strobes.rise) begin
            sclk  <= 1'b1;
            phCnt <= highLen - PH_W'(1);
            state <= S_HIGH;
          end else begin
            phCnt <= phCnt - PH_W'(1);
          end
        end
        S_HIGH: begin
          if (strobes.fall) begin
            sclk <= 1'b0;
            if (strobes.finish) begin
              frame <= 1'b0;
              state <= S_IDLE;
            end else begin
              bitCnt <= bitCnt + LEN_W'(1);
              phCnt  <= lowLen - PH_W'(1);
              state  <= S_LOW;
            end
          end else begin
            phCnt <= phCnt - PH_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_clkstop_dp.sv
module spi_clkstop_dp
  import spi_clkstop_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [LEN_W-1:0]    lenNext,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                miso,
  output logic                mosi,
  output logic                mosiOe,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                rxDone
);
  logic [MAX_BITS-1:0] shTx;
  logic [MAX_BITS-1:0] shRx;
  logic [MAX_BITS-1:0] rxNext;
  logic [LEN_W-1:0]    alignShift;

  assign alignShift = LEN_W'(MAX_BITS) - lenNext;
  assign rxNext     = {shRx[MAX_BITS-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shTx   <= '0;
      shRx   <= '0;
      mosi   <= 1'b0;
      mosiOe <= 1'b0;
      rxWord <= '0;
      rxDone <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (strobes.load) begin
        shTx <= txWord << alignShift;   // MSB of the word lands in the top bit
        shRx <= '0;
      end
      if (strobes.rise) begin
        mosi   <= shTx[MAX_BITS-1];
        shTx   <= shTx << 1;
        mosiOe <= 1'b1;
      end
      if (strobes.fall) begin
        shRx <= rxNext;
        if (strobes.finish) begin
          rxWord <= rxNext;
          rxDone <= 1'b1;
          mosiOe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_clkstop_master.sv
module spi_clkstop_master
  import spi_clkstop_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    divSet,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                start,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                miso,
  output logic                sclk,
  output logic                csN,
  output logic                mosi,
  output logic                mosiOe,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                rxDone
);
  ctlStrobes_t      strobes;
  logic [LEN_W-1:0] lenNext;
  logic             frame;

  spi_clkstop_ctrl #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .divSet(divSet), .wordLen(wordLen),
    .strobes(strobes), .lenNext(lenNext), .sclk(sclk), .frame(frame)
  );

  spi_clkstop_dp #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lenNext(lenNext), .txWord(txWord),
    .miso(miso), .mosi(mosi), .mosiOe(mosiOe), .rxWord(rxWord), .rxDone(rxDone)
  );

  // The internal frame is active high; the pin is active low.
  assign csN = ~frame;
endmodule

// File: rtl/spi_clkstop_sva.sv
module spi_clkstop_sva #(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [DIV_W-1:0]    divSet,
  input logic [LEN_W-1:0]    wordLen,
  input logic                start,
  input logic [MAX_BITS-1:0] txWord,
  input logic                miso,
  input logic                sclk,
  input logic                csN,
  input logic                mosi,
  input logic                mosiOe,
  input logic [MAX_BITS-1:0] rxWord,
  input logic                rxDone
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sclk && !mosiOe));

  p_clock_in_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> !csN);

  p_frame_opens_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (!sclk && $past(start)));

  p_mosi_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mosiOe && $past(mosiOe) && (mosi != $past(mosi))) |-> $rose(sclk));

  p_oe_with_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mosiOe) |-> $rose(sclk));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  p_done_closes_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (csN && $past(!csN) && $fell(sclk)));
endmodule

bind spi_clkstop_master spi_clkstop_sva #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) sva_i (.*);

// File: tb/spi_clkstop_master_tb_top.sv
`timescale 1ns/1ps
module spi_clkstop_master_tb_top;
  localparam int DIV_W = 8;
  localparam int MAX_BITS = 32;
  localparam int LEN_W = $clog2(MAX_BITS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] divSet = '0;
  logic [LEN_W-1:0] wordLen = LEN_W'(8);
  logic start = 1'b0;
  logic [MAX_BITS-1:0] txWord = '0;
  logic miso = 1'b0;
  logic sclk, csN, mosi, mosiOe, rxDone;
  logic [MAX_BITS-1:0] rxWord;

  int checks = 0;
  int errs = 0;

  always #2 clk = ~clk;

  spi_clkstop_master #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .divSet(divSet), .wordLen(wordLen), .start(start),
    .txWord(txWord), .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi),
    .mosiOe(mosiOe), .rxWord(rxWord), .rxDone(rxDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int effLen(input int l);
    return (l < 8) ? 8 : ((l > MAX_BITS) ? MAX_BITS : l);
  endfunction

  function automatic int expLow(input int d);
    return (d == 0 || (d % 2) == 1) ? d + 1 : d;
  endfunction

  function automatic int expHigh(input int d);
    return 2 * (d + 1) - expLow(d);
  endfunction

  function automatic logic [63:0] maskOf(input int l);
    return (64'd1 << l) - 64'd1;
  endfunction

  task automatic runXfer(input int d, input int l, input logic [MAX_BITS-1:0] tx,
                         input logic [MAX_BITS-1:0] sw, input bit midStart);
    int n = effLen(l);
    logic prev = 1'b0;
    int run = 0;
    int bits = 0;
    int guard = 0;
    bit firstLow = 1'b1;
    bit clearStart = 1'b0;
    logic [63:0] got = '0;
    @(negedge clk);
    divSet = DIV_W'(d); wordLen = LEN_W'(l); txWord = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(csN == 1'b0 && sclk == 1'b0, "R4 csN low with sclk low", {csN, sclk}, 0);
    chk(mosiOe == 1'b0, "R5 oe off before first rise", mosiOe, 0);
    forever begin
      if (clearStart) begin
        start = 1'b0; divSet = DIV_W'(d); wordLen = LEN_W'(l); clearStart = 1'b0;
      end
      if (sclk != prev) begin
        if (sclk) begin
          chk(run == expLow(d), firstLow ? "R4 lead low phase" : "R3 low phase", run, expLow(d));
          firstLow = 1'b0;
          chk(mosiOe == 1'b1, "R5 oe on during bits", mosiOe, 1);
          got = {got[62:0], mosi};
          miso = sw[n - 1 - bits];
          bits++;
          if (midStart && bits == 3) begin
            start = 1'b1; txWord = ~tx; divSet = DIV_W'(d + 3); wordLen = LEN_W'(l + 5);
            clearStart = 1'b1;
          end
        end else begin
          chk(run == expHigh(d), "R2 R3 high phase", run, expHigh(d));
        end
        run = 0;
      end
      if (rxDone) begin
        chk(csN == 1'b1 && mosiOe == 1'b0 && sclk == 1'b0, "R7 frame closes", {csN, mosiOe, sclk}, 3'b100);
        chk(bits == n, "R8 R10 bit count", bits, n);
        chk(got == (64'(tx) & maskOf(n)), "R5 mosi word", got, 64'(tx) & maskOf(n));
        chk(64'(rxWord) == (64'(sw) & maskOf(n)), "R6 rxWord", rxWord, 64'(sw) & maskOf(n));
        break;
      end else if (!csN) begin
        // no early close
      end else begin
        chk(1'b0, "R7 csN rose without rxDone", csN, 0);
        break;
      end
      run++;
      prev = sclk;
      guard++;
      if (guard > 20000) begin
        chk(1'b0, "R7 transfer never ended", guard, 0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(rxDone == 1'b0, "R7 done one cycle", rxDone, 0);
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && rxDone == 1'b0, midStart ? "R9 no second frame" : "R1 idle after frame",
        {csN, rxDone}, 2'b10);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0 && mosiOe == 1'b0 && rxDone == 1'b0,
        "R1 reset state", {csN, sclk, mosiOe, rxDone}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R1 idle after reset", {csN, sclk}, 2'b10);

    // Directed corners: divide settings 0, odd and even; length clamp; mid-frame start.
    runXfer(0, 8,  32'hA5, 32'h3C, 1'b0);
    runXfer(1, 16, 32'hBEEF, 32'h1234, 1'b0);
    runXfer(2, 8,  32'h81, 32'hFF, 1'b0);
    runXfer(4, 12, 32'hABC, 32'h5A5, 1'b0);
    runXfer(10, 9, 32'h1FF, 32'h0AA, 1'b0);
    runXfer(3, 3,  32'hFFFF_FF96, 32'hFFFF_FF69, 1'b0);   // R8 clamp up to 8
    runXfer(0, 40, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0);   // R8 clamp down to 32
    runXfer(2, 32, 32'h8000_0001, 32'h7FFF_FFFE, 1'b1);   // R9 R10
    runXfer(5, 10, 32'h2AA, 32'h155, 1'b1);               // R9 R10

    for (int i = 0; i < 40; i++) begin
      runXfer(int'($urandom % 10), int'($urandom % 41), $urandom, $urandom, ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule